// File: doc/BRIEF.md
# Data-Processing ALU with Flags

This block carries out the sixteen data-processing operations of a 32-bit integer datapath. It takes a first operand and an already shifted second operand, together with the shifter carry-out and a marker that says whether the shifter actually rotated or shifted. It produces the 32-bit result and the new N, Z, C and V flags, and it tells the register file whether to write the result, whether to write the flags, and whether the program counter is being written.

A flag-setting operation whose destination is register 15 is handled as an atomic status restore. The flags are left alone, and the block asks for the saved status word to be copied into the current status word. That request is refused and an error is raised when the current mode is user mode, or when the saved word carries a mode code that is not recognised. On such an error neither the result nor the flags are written.

Every output is registered. The block accepts one operation per cycle under `valid_i`, and the outcome appears on the outputs in the cycle after.

Top module: `dp_alu`

## Requirements
- R1: Opcode codes: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The logical codes (0, 1, 8, 9, 12 to 15) give AND, XOR, OR, pass of op2, op1 AND NOT op2, and NOT op2.
- R2: The arithmetic codes compute a + b + cin. SUB and CMP use op1, ~op2 and cin 1. RSB uses ~op1, op2 and cin 1. ADD and CMN use op1, op2 and cin 0. ADC, SBC and RSC follow ADD, SUB and RSB respectively, but take the current C flag as cin.
- R3: For arithmetic codes, the new C is the carry out of bit 31, so a subtraction without borrow gives C=1.
- R4: For arithmetic codes, V is set when both addends have equal sign bits and the result's sign bit differs from them.
- R5: For logical codes, V keeps its current value. C takes the shifter carry-out when the shift-applied input is 1, and keeps its current value when it is 0.
- R6: N equals bit 31 of the result, and Z is 1 exactly when the 32-bit result is zero.
- R7: Codes 8 to 11 never assert the result write enable.
- R8: The flags write enable is asserted only for a valid operation with set-flags 1 and a destination other than 15. Flag bit order is {N,Z,C,V} from bit 3 down to bit 0.
- R9: Set-flags 1 with destination 15 gives a restore request carrying the saved status word, and no flag write.
- R10: The restore is an error, with no restore, result write or flag write, when the current mode is 5'h10 (user) or the saved word's bits 4:0 are not one of 11, 12, 13, 17, 1B or 1F hex. Mode 10 hex is also valid as a saved mode.
- R11: A result write to destination 15 asserts the program-counter-written output.
- R12: Outputs appear one cycle after `valid_i`. A cycle without `valid_i` and the reset state show all enables, restore and error at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Update flags |
| rd_i | input | 4 | Destination register index |
| op1_i | input | 32 | First operand |
| op2_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Shifter carry-out |
| shift_applied_i | input | 1 | Shifter rotated or shifted this operand |
| flags_i | input | 4 | Current {N,Z,C,V} |
| mode_i | input | 5 | Current mode code |
| spsr_i | input | 32 | Saved status word |
| valid_o | output | 1 | Outcome present |
| result_o | output | 32 | Result |
| result_rd_o | output | 4 | Result destination index |
| result_we_o | output | 1 | Write the result |
| flags_o | output | 4 | New {N,Z,C,V} |
| flags_we_o | output | 1 | Write the flags |
| restore_o | output | 1 | Copy saved status into current status |
| restore_psr_o | output | 32 | Status word to restore |
| pc_written_o | output | 1 | Result goes to register 15 |
| error_o | output | 1 | Illegal status restore |

## Verification
Every output comes from one register stage, so each result, flag, enable and restore signal is due exactly one cycle after the operation is presented. The bench drives inputs on a falling edge, lets one rising edge register them, and compares on the next falling edge. It then drives the following operation from that same point, so each comparison sees the outputs of exactly one operation. A final idle cycle confirms that the enables drop in the cycle after `valid_i` falls.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam logic [4:0] MODE_USER = 5'h10;

  function automatic logic is_test(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_logic(alu_op_e op);
    return op[3:2] == 2'b11 || op == OP_AND || op == OP_EOR || op == OP_TST || op == OP_TEQ;
  endfunction

  function automatic logic mode_ok(logic [4:0] m);
    case (m)
      5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   op1_i,
  input  logic [DW-1:0]   op2_i,
  input  logic            c_i,
  output logic [DW-1:0]   sum_o,
  output logic            cout_o,
  output logic            ovf_o
);
  logic [DW-1:0] a, b;
  logic          ci;

  always_comb begin
    a  = op1_i;
    b  = op2_i;
    ci = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin b = ~op2_i; ci = 1'b1; end
      OP_RSB:         begin a = ~op1_i; ci = 1'b1; end
      OP_ADC:         ci = c_i;
      OP_SBC:         begin b = ~op2_i; ci = c_i; end
      OP_RSC:         begin a = ~op1_i; ci = c_i; end
      default: ;
    endcase
  end

  assign {cout_o, sum_o} = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  assign ovf_o = (a[DW-1] == b[DW-1]) && (sum_o[DW-1] != a[DW-1]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] op1_i,
  input  logic [DW-1:0] op2_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TST: res_o = op1_i & op2_i;
      OP_EOR, OP_TEQ: res_o = op1_i ^ op2_i;
      OP_ORR:         res_o = op1_i | op2_i;
      OP_MOV:         res_o = op2_i;
      OP_BIC:         res_o = op1_i & ~op2_i;
      OP_MVN:         res_o = ~op2_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          logic_op_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          ovf_i,
  input  logic          shift_carry_i,
  input  logic          shift_applied_i,
  input  nzcv_t         cur_i,
  output nzcv_t         nzcv_o
);
  always_comb begin
    nzcv_o.n = res_i[DW-1];
    nzcv_o.z = (res_i == '0);
    if (logic_op_i) begin
      nzcv_o.c = shift_applied_i ? shift_carry_i : cur_i.c;
      nzcv_o.v = cur_i.v;
    end else begin
      nzcv_o.c = cout_i;
      nzcv_o.v = ovf_i;
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RIDX_W = 4,
  parameter int unsigned MODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        opcode_i,
  input  logic              set_flags_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [DW-1:0]     op1_i,
  input  logic [DW-1:0]     op2_i,
  input  logic              shift_carry_i,
  input  logic              shift_applied_i,
  input  logic [3:0]        flags_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     spsr_i,
  output logic              valid_o,
  output logic [DW-1:0]     result_o,
  output logic [RIDX_W-1:0] result_rd_o,
  output logic              result_we_o,
  output logic [3:0]        flags_o,
  output logic              flags_we_o,
  output logic              restore_o,
  output logic [DW-1:0]     restore_psr_o,
  output logic              pc_written_o,
  output logic              error_o
);
  localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};

  alu_op_e       op;
  nzcv_t         cur, nzcv;
  logic [DW-1:0] sum, lres, res;
  logic          cout, ovf, lop;
  logic          to_pc, hit_pc, bad_rst, wr_res;

  assign op  = alu_op_e'(opcode_i);
  assign cur = nzcv_t'(flags_i);
  assign lop = is_logic(op);

  dp_alu_addsub #(.DW(DW)) u_addsub (
    .op_i(op), .op1_i(op1_i), .op2_i(op2_i), .c_i(cur.c),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  dp_alu_logic #(.DW(DW)) u_logic (
    .op_i(op), .op1_i(op1_i), .op2_i(op2_i), .res_o(lres)
  );

  assign res = lop ? lres : sum;

  dp_alu_flags #(.DW(DW)) u_flags (
    .logic_op_i(lop), .res_i(res), .cout_i(cout), .ovf_i(ovf),
    .shift_carry_i(shift_carry_i), .shift_applied_i(shift_applied_i),
    .cur_i(cur), .nzcv_o(nzcv)
  );

  assign to_pc   = (rd_i == PC_IDX);
  assign hit_pc  = set_flags_i && to_pc;
  assign bad_rst = hit_pc && ((mode_i == MODE_USER) || !mode_ok(spsr_i[4:0]));
  assign wr_res  = !is_test(op) && !bad_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      result_we_o   <= 1'b0;
      flags_we_o    <= 1'b0;
      restore_o     <= 1'b0;
      pc_written_o  <= 1'b0;
      error_o       <= 1'b0;
      result_o      <= '0;
      result_rd_o   <= '0;
      flags_o       <= '0;
      restore_psr_o <= '0;
    end else begin
      valid_o      <= valid_i;
      result_we_o  <= valid_i && wr_res;
      flags_we_o   <= valid_i && set_flags_i && !to_pc;
      restore_o    <= valid_i && hit_pc && !bad_rst;
      pc_written_o <= valid_i && wr_res && to_pc;
      error_o      <= valid_i && bad_rst;
      if (valid_i) begin
        result_o      <= res;
        result_rd_o   <= rd_i;
        flags_o       <= nzcv;
        restore_psr_o <= spsr_i;
      end
    end
  end

  assert_test_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_test(op)) |=> !result_we_o);
  assert_logic_keeps_v_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lop) |=> (flags_o[0] == $past(flags_i[0])));
  assert_zero_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_o |-> (flags_o[2] == (result_o == '0)) && (flags_o[3] == result_o[DW-1]));
  assert_restore_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restore_o && flags_we_o));
  assert_error_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!restore_o && !result_we_o && !flags_we_o));
  assert_pc_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_written_o |-> (result_we_o && result_rd_o == PC_IDX));
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(result_we_o || flags_we_o || restore_o || error_o));
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  rd_i = '0;
  logic [31:0] op1_i = '0, op2_i = '0, spsr_i = '0;
  logic        shift_carry_i = 1'b0, shift_applied_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic [4:0]  mode_i = 5'h13;
  logic        valid_o, result_we_o, flags_we_o, restore_o, pc_written_o, error_o;
  logic [31:0] result_o, restore_psr_o;
  logic [3:0]  result_rd_o, flags_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  dp_alu dut (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .set_flags_i, .rd_i, .op1_i, .op2_i,
    .shift_carry_i, .shift_applied_i, .flags_i, .mode_i, .spsr_i,
    .valid_o, .result_o, .result_rd_o, .result_we_o, .flags_o, .flags_we_o,
    .restore_o, .restore_psr_o, .pc_written_o, .error_o
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic cf, input logic vf, input logic sa, input logic sc,
                       output logic [31:0] r, output logic [3:0] f);
    logic [32:0] s;
    logic [31:0] x, y;
    logic ci, lg, c, v;
    lg = 1'b1; x = a; y = b; ci = 1'b0; s = '0; r = '0;
    case (op)
      0, 8:  r = a & b;
      1, 9:  r = a ^ b;
      12:    r = a | b;
      13:    r = b;
      14:    r = a & ~b;
      15:    r = ~b;
      default: lg = 1'b0;
    endcase
    if (!lg) begin
      case (op)
        2, 10: begin y = ~b; ci = 1'b1; end
        3:     begin x = ~a; ci = 1'b1; end
        5:     ci = cf;
        6:     begin y = ~b; ci = cf; end
        7:     begin x = ~a; ci = cf; end
        default: ci = 1'b0;
      endcase
      s = {1'b0, x} + {1'b0, y} + {32'd0, ci};
      r = s[31:0];
    end
    c = lg ? (sa ? sc : cf) : s[32];
    v = lg ? vf : ((x[31] == y[31]) && (r[31] != x[31]));
    f = {r[31], r == 32'd0, c, v};
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: pat = 32'h0000_0000;
      1: pat = 32'h0000_0001;
      2: pat = 32'hFFFF_FFFF;
      3: pat = 32'h8000_0000;
      4: pat = 32'h7FFF_FFFF;
      default: pat = 32'h1234_5678;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] er;
    logic [3:0]  ef;
    repeat (2) @(negedge clk_i);
    // R12 reset state
    ceq("R12 reset we", {result_we_o, flags_we_o, restore_o, error_o, pc_written_o, valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int sf = 0; sf < 2; sf++)
      for (int op = 0; op < 16; op++)
        for (int pi = 0; pi < 6; pi++)
          for (int fc = 0; fc < 8; fc++) begin
            logic tst;
            valid_i = 1'b1; opcode_i = 4'(op); set_flags_i = sf[0]; rd_i = 4'd3;
            op1_i = pat(pi); op2_i = pat((pi * 5 + 2) % 6);
            flags_i = {fc[1], fc[0], fc[0], fc[1]};
            shift_applied_i = fc[2]; shift_carry_i = ~fc[0];
            model(op, op1_i, op2_i, fc[0], fc[1], fc[2], ~fc[0], er, ef);
            tst = (op >= 8 && op <= 11);
            @(negedge clk_i);
            ceq(op >= 2 && op <= 7 ? "R2 result" : "R1 result", result_o, er);
            ceq("R7 result_we", {31'd0, result_we_o}, {31'd0, !tst});
            ceq("R8 flags_we", {31'd0, flags_we_o}, {31'd0, sf[0]});
            ceq("R12 valid", {31'd0, valid_o}, 32'd1);
            ceq("R6 nz", {30'd0, flags_o[3:2]}, {30'd0, ef[3:2]});
            ceq((op >= 2 && op <= 7) || op == 10 || op == 11 ? "R3 carry" : "R5 carry",
                {31'd0, flags_o[1]}, {31'd0, ef[1]});
            ceq((op >= 2 && op <= 7) || op == 10 || op == 11 ? "R4 ovf" : "R5 ovf",
                {31'd0, flags_o[0]}, {31'd0, ef[0]});
            ceq("R9 no restore", {30'd0, restore_o, error_o}, 0);
          end

    // R9 restore in privileged mode
    valid_i = 1'b1; opcode_i = 4'd13; set_flags_i = 1'b1; rd_i = 4'd15;
    op2_i = 32'h0000_0100; mode_i = 5'h13; spsr_i = 32'hA000_001F; flags_i = 4'b0000;
    @(negedge clk_i);
    ceq("R9 restore", {31'd0, restore_o}, 1);
    ceq("R9 restore psr", restore_psr_o, 32'hA000_001F);
    ceq("R9 no flag write", {31'd0, flags_we_o}, 0);
    ceq("R11 pc written", {31'd0, pc_written_o}, 1);
    // R7 compare with rd 15 restores, no result write
    opcode_i = 4'd10; spsr_i = 32'h0000_0010;
    @(negedge clk_i);
    ceq("R7 cmp pc no write", {30'd0, result_we_o, pc_written_o}, 0);
    ceq("R10 user saved mode ok", {31'd0, restore_o}, 1);
    // R10 user mode
    opcode_i = 4'd13; mode_i = 5'h10; spsr_i = 32'h0000_0013;
    @(negedge clk_i);
    ceq("R10 user error", {31'd0, error_o}, 1);
    ceq("R10 user blocked", {29'd0, restore_o, result_we_o, flags_we_o}, 0);
    // R10 invalid saved mode
    mode_i = 5'h1F; spsr_i = 32'h0000_0000;
    @(negedge clk_i);
    ceq("R10 bad mode error", {31'd0, error_o}, 1);
    ceq("R10 bad mode blocked", {30'd0, restore_o, pc_written_o}, 0);
    // R11 plain write to pc
    set_flags_i = 1'b0; opcode_i = 4'd4; op1_i = 32'd8; op2_i = 32'd4;
    @(negedge clk_i);
    ceq("R11 add pc", {30'd0, pc_written_o, result_we_o}, 3);
    ceq("R11 result", result_o, 32'd12);
    ceq("R11 rd", {28'd0, result_rd_o}, 32'd15);
    ceq("R8 no flags", {30'd0, flags_we_o, restore_o}, 0);
    // R12 idle cycle
    valid_i = 1'b0;
    @(negedge clk_i);
    ceq("R12 idle", {result_we_o, flags_we_o, restore_o, error_o, pc_written_o, valid_o}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule